// File: doc/BRIEF.md
# Steered Watchdog Timer

This block counts down a programmable interval measured in ticks of an external 1/16-second strobe. The interval comes from one 8-bit control register. Bits 6:2 hold a multiplier and bits 1:0 hold a resolution exponent. The interval in ticks is the multiplier times four raised to the exponent. A register value that gives an interval of zero leaves the watchdog idle.

Software keeps the watchdog alive by touching the register. A write loads a new interval and restarts the countdown. A read restarts the countdown with the interval already held. If the count runs out, the block raises a sticky expiry flag. Bit 7 of the register then steers the response. With bit 7 set, the block issues a one-cycle reset request, clears the register, and pulses a strobe that tells a neighbouring calendar register to clear its century bit. With bit 7 clear, the block issues a one-cycle interrupt pulse and keeps the register.

Each countdown runs once. After an expiry, the block waits for the next restart.

Top module: `wdog_steer`

## Requirements
- R1: The interval in ticks is N = M * 4^E, where M = bits 6:2 and E = bits 1:0 of the control value. The expiry outputs change on the clock edge that samples the N-th tick after the restart.
- R2: A control value whose interval is zero never expires. This covers 0x00, and also any value with M = 0 and E nonzero.
- R3: A write (`wr_en_i`) stores `wr_data_i` and restarts the countdown with the new interval. If a write and a read occur in the same cycle, the write wins.
- R4: A read (`rd_en_i`) restarts the countdown with the stored interval and leaves the register unchanged. `rd_data_o` always presents the stored value.
- R5: An expiry sets `flag_o`. Any restart clears it.
- R6: On expiry with bit 7 set, `rst_req_o` and `century_clr_o` are high for exactly one cycle, `irq_o` stays low, and the register reads 0x00 from that edge on.
- R7: On expiry with bit 7 clear, `irq_o` is high for exactly one cycle, `rst_req_o` and `century_clr_o` stay low, and the register is kept.
- R8: After an expiry, further ticks produce no output until the next restart.
- R9: While `rst_n` is low at a clock edge, the register clears to 0x00, the countdown stops, and all outputs go low.
- R10: A restart in the same cycle as the tick that would end the count takes priority. No expiry occurs, and the full interval starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe every 1/16 second |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Value to write |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 8 | Current register value |
| flag_o | output | 1 | Sticky expiry flag |
| rst_req_o | output | 1 | One-cycle reset request |
| irq_o | output | 1 | One-cycle interrupt pulse |
| century_clr_o | output | 1 | One-cycle strobe to clear the neighbour's century bit |

## Verification
Every result of this block is due on the first clock edge that samples its cause:
- The register contents and the cleared flag follow a strobe at that edge.
- The flag, the pulses and the register clear follow the N-th tick at that edge.
- Each pulse is gone after the edge that follows.

The bench drives strobes at a falling edge and holds them for one full cycle. It samples at the next falling edge, so it sees the first cycle of each result, and it samples again one cycle later to confirm that each pulse lasts one cycle. Tick counts up to the first pulse are compared against M * 4^E computed in the bench.

// File: rtl/wdg_pkg.sv
// Package: shared field layout of the watchdog control register.
// Assumes an 8-bit register with multiplier, exponent and steering fields.
package wdg_pkg;
    localparam int CFG_W     = 8;
    localparam int MULT_LSB  = 2;
    localparam int MULT_W    = 5;
    localparam int EXP_W     = 2;
    localparam int STEER_BIT = 7;
    // Count must hold MULT_max * 4^(EXP_max)
    localparam int SPAN_W    = MULT_W + 2 * ((1 << EXP_W) - 1);
endpackage

// File: rtl/wdg_cfg_reg.sv
// Module: holds the watchdog control register.
// Writes take priority; an expiry steered to reset clears the register.
// Assumes clr_i never coincides with wr_en_i (a write blocks expiry).
module wdg_cfg_reg #(
    parameter int CFG_W = wdg_pkg::CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [CFG_W-1:0] wr_data_i,
    input  logic             clr_i,
    output logic [CFG_W-1:0] cfg_o
);
    logic [CFG_W-1:0] cfg_q;

    // Store writes, clear on a reset-steered expiry
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (wr_en_i) cfg_q <= wr_data_i;
        else if (clr_i)   cfg_q <= '0;
    end

    assign cfg_o = cfg_q;

    // R6
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !wr_en_i) |=> (cfg_o == '0));
    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (cfg_o == $past(wr_data_i)));
endmodule

// File: rtl/wdg_span_calc.sv
// Module: converts a control value into an interval in ticks.
// Interval = multiplier * 4^exponent; purely combinational.
module wdg_span_calc #(
    parameter int CFG_W    = wdg_pkg::CFG_W,
    parameter int MULT_LSB = wdg_pkg::MULT_LSB,
    parameter int MULT_W   = wdg_pkg::MULT_W,
    parameter int EXP_W    = wdg_pkg::EXP_W,
    parameter int SPAN_W   = wdg_pkg::SPAN_W
) (
    input  logic [CFG_W-1:0]  cfg_i,
    output logic [SPAN_W-1:0] span_o
);
    localparam int N_EXP = 1 << EXP_W;

    logic [MULT_W-1:0] mult;
    logic [EXP_W-1:0]  expo;
    logic [SPAN_W-1:0] cand [N_EXP];

    assign mult = cfg_i[MULT_LSB +: MULT_W];
    assign expo = cfg_i[EXP_W-1:0];

    // One shifted candidate per exponent value
    for (genvar e = 0; e < N_EXP; e++) begin : g_scale
        assign cand[e] = SPAN_W'(mult) << (2 * e);
    end

    // Pick the candidate selected by the exponent field
    always_comb begin
        span_o = cand[expo];
    end
endmodule

// File: rtl/wdg_counter.sv
// Module: one-shot down counter of ticks.
// A restart loads the interval; a zero interval leaves the counter idle.
// Restart has priority over a tick in the same cycle.
module wdg_counter #(
    parameter int SPAN_W = wdg_pkg::SPAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              restart_i,
    input  logic [SPAN_W-1:0] load_i,
    output logic              expire_o,
    output logic              armed_o
);
    logic [SPAN_W-1:0] cnt_q;
    logic              armed_q;
    logic              last_tick;

    assign last_tick = armed_q && tick_i && (cnt_q == SPAN_W'(1));
    assign expire_o  = last_tick && !restart_i;
    assign armed_o   = armed_q;

    // Load on restart, count down on ticks, stop at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (restart_i) begin
            cnt_q   <= load_i;
            armed_q <= (load_i != '0);
        end else if (armed_q && tick_i) begin
            cnt_q <= cnt_q - SPAN_W'(1);
            if (cnt_q == SPAN_W'(1)) armed_q <= 1'b0;
        end
    end

    // R8
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !restart_i) |=> !armed_o);
    // R10
    restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |-> !expire_o);
endmodule

// File: rtl/wdg_outcome.sv
// Module: turns an expiry into the flag and the steered pulses.
// Pulses are registered and last one cycle; the flag is sticky until restart.
module wdg_outcome (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic restart_i,
    input  logic steer_i,
    output logic flag_o,
    output logic rst_req_o,
    output logic irq_o,
    output logic side_clr_o
);
    // Sticky expiry flag, cleared by any restart
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_o <= 1'b0;
        else if (restart_i) flag_o <= 1'b0;
        else if (expire_i)  flag_o <= 1'b1;
    end

    // One-cycle steered response pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_o  <= 1'b0;
            irq_o      <= 1'b0;
            side_clr_o <= 1'b0;
        end else begin
            rst_req_o  <= expire_i && steer_i;
            irq_o      <= expire_i && !steer_i;
            side_clr_o <= expire_i && steer_i;
        end
    end

    // R5
    flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_o);
    // R5
    flag_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !flag_o);
    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R6
    steer_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, rst_req_o}));
endmodule

// File: rtl/wdog_steer.sv
// Module: top of the steered watchdog timer.
// Any register access restarts the countdown; the write value wins over the
// stored value when both strobes are present. Assumes tick_i is one cycle wide.
module wdog_steer #(
    parameter int CFG_W     = wdg_pkg::CFG_W,
    parameter int MULT_LSB  = wdg_pkg::MULT_LSB,
    parameter int MULT_W    = wdg_pkg::MULT_W,
    parameter int EXP_W     = wdg_pkg::EXP_W,
    parameter int STEER_BIT = wdg_pkg::STEER_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [CFG_W-1:0] wr_data_i,
    input  logic             rd_en_i,
    output logic [CFG_W-1:0] rd_data_o,
    output logic             flag_o,
    output logic             rst_req_o,
    output logic             irq_o,
    output logic             century_clr_o
);
    localparam int SPAN_W = MULT_W + 2 * ((1 << EXP_W) - 1);

    logic [CFG_W-1:0]  cfg_q;
    logic [CFG_W-1:0]  cfg_sel;
    logic [SPAN_W-1:0] span;
    logic              restart;
    logic              expire;
    logic              armed;
    logic              steer;

    assign restart = wr_en_i || rd_en_i;
    assign cfg_sel = wr_en_i ? wr_data_i : cfg_q;
    assign steer   = cfg_q[STEER_BIT];

    wdg_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .clr_i     (expire && steer),
        .cfg_o     (cfg_q)
    );

    wdg_span_calc #(
        .CFG_W    (CFG_W),
        .MULT_LSB (MULT_LSB),
        .MULT_W   (MULT_W),
        .EXP_W    (EXP_W),
        .SPAN_W   (SPAN_W)
    ) u_span (
        .cfg_i  (cfg_sel),
        .span_o (span)
    );

    wdg_counter #(.SPAN_W(SPAN_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .restart_i (restart),
        .load_i    (span),
        .expire_o  (expire),
        .armed_o   (armed)
    );

    wdg_outcome u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_i   (expire),
        .restart_i  (restart),
        .steer_i    (steer),
        .flag_o     (flag_o),
        .rst_req_o  (rst_req_o),
        .irq_o      (irq_o),
        .side_clr_o (century_clr_o)
    );

    assign rd_data_o = cfg_q;

    // R2
    zero_mult_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_data_i[MULT_LSB +: MULT_W] == '0)) |=> !armed);
    // R6
    reset_clears_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (rd_data_o == '0));
    // R4
    read_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !wr_en_i) |=> $stable(rd_data_o));
endmodule

// File: tb/tb_wdog_steer.sv
module tb_wdog_steer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       rd_en_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       flag_o, rst_req_o, irq_o, century_clr_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    wdog_steer dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
        .flag_o(flag_o), .rst_req_o(rst_req_o), .irq_o(irq_o),
        .century_clr_o(century_clr_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk) begin wr_en_i = 1'b1; wr_data_i = v; end
        @(negedge clk) wr_en_i = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk) rd_en_i = 1'b1;
        @(negedge clk) rd_en_i = 1'b0;
    endtask

    function automatic int span_of(input logic [7:0] v);
        return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
    endfunction

    // Ticks until the first pulse; 0 if none within lim ticks
    task automatic ticks_to_pulse(input int lim, output int seen);
        seen = 0;
        for (int i = 1; i <= lim; i++) begin
            do_tick();
            if (irq_o || rst_req_o) begin seen = i; break; end
        end
    endtask

    task automatic t_reset();
        chk("R9 rd_data after reset", rd_data_o, 0);
        chk("R9 flag after reset", flag_o, 0);
        chk("R9 pulses after reset", {irq_o, rst_req_o, century_clr_o}, 0);
    endtask

    task automatic t_span(input logic [7:0] v);
        int seen;
        do_write(v);
        ticks_to_pulse(span_of(v) + 2, seen);
        chk($sformatf("R1 ticks to expiry for 0x%02h", v), seen, span_of(v));
        chk("R7 irq high on expiry", irq_o, 1);
        chk("R7 no reset request", rst_req_o | century_clr_o, 0);
        chk("R7 register kept", rd_data_o, int'(v));
        chk("R5 flag set on expiry", flag_o, 1);
        @(negedge clk);
        chk("R7 irq lasts one cycle", irq_o, 0);
    endtask

    task automatic t_disabled(input logic [7:0] v);
        int seen;
        do_write(v);
        ticks_to_pulse(70, seen);
        chk($sformatf("R2 no expiry for 0x%02h", v), seen, 0);
    endtask

    task automatic t_write_restart();
        int seen;
        do_write(8'h0C);
        do_tick(); do_tick();
        do_write(8'h05);
        ticks_to_pulse(8, seen);
        chk("R3 write restarts with new interval", seen, 4);
    endtask

    task automatic t_read_restart();
        int seen;
        do_write(8'h0C);
        do_tick(); do_tick();
        do_read();
        chk("R4 read keeps value", rd_data_o, 8'h0C);
        ticks_to_pulse(6, seen);
        chk("R4 read restarts with stored interval", seen, 3);
        chk("R5 flag set before read", flag_o, 1);
        do_read();
        chk("R5 read clears flag", flag_o, 0);
    endtask

    task automatic t_wr_rd_same();
        int seen;
        do_write(8'h14);
        @(negedge clk) begin wr_en_i = 1'b1; rd_en_i = 1'b1; wr_data_i = 8'h08; end
        @(negedge clk) begin wr_en_i = 1'b0; rd_en_i = 1'b0; end
        chk("R3 write wins over read", rd_data_o, 8'h08);
        ticks_to_pulse(6, seen);
        chk("R3 new interval after joint access", seen, 2);
    endtask

    task automatic t_race();
        int seen;
        do_write(8'h0C);
        do_tick(); do_tick();
        @(negedge clk) begin tick_i = 1'b1; rd_en_i = 1'b1; end
        @(negedge clk) begin tick_i = 1'b0; rd_en_i = 1'b0; end
        chk("R10 no expiry on restart cycle", irq_o | rst_req_o, 0);
        ticks_to_pulse(6, seen);
        chk("R10 full interval restarts", seen, 3);
    endtask

    task automatic t_steer();
        int seen;
        do_write(8'h8C);
        ticks_to_pulse(6, seen);
        chk("R6 ticks to reset request", seen, 3);
        chk("R6 reset request high", rst_req_o, 1);
        chk("R6 century clear high", century_clr_o, 1);
        chk("R6 no irq", irq_o, 0);
        chk("R6 register cleared", rd_data_o, 0);
        chk("R5 flag set", flag_o, 1);
        @(negedge clk);
        chk("R6 pulses last one cycle", rst_req_o | century_clr_o, 0);
        ticks_to_pulse(10, seen);
        chk("R8 no output after reset expiry", seen, 0);
    endtask

    task automatic t_one_shot();
        int seen;
        do_write(8'h04);
        ticks_to_pulse(3, seen);
        chk("R1 single tick interval", seen, 1);
        ticks_to_pulse(20, seen);
        chk("R8 no repeat without restart", seen, 0);
    endtask

    task automatic t_mid_reset();
        int seen;
        do_write(8'h0C);
        do_tick();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R9 register cleared by reset", rd_data_o, 0);
        ticks_to_pulse(8, seen);
        chk("R9 countdown stopped by reset", seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_span(8'h0C);
        t_span(8'h05);
        t_span(8'h09);
        t_span(8'h06);
        t_span(8'h07);
        t_span(8'h7F);
        t_disabled(8'h00);
        t_disabled(8'h03);
        t_write_restart();
        t_read_restart();
        t_wr_rd_same();
        t_race();
        t_steer();
        t_one_shot();
        t_mid_reset();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule